// File: doc/BRIEF.md
# Streaming Single-Occurrence Word Finder

This block watches a stream of 32-bit words, one word per valid beat. In the intended use, every value appears exactly three times except one value, which appears once. The block recovers that single value without storing the stream or sorting it.

For each bit position, two state registers (`lower_q` and `higher_q`) together hold a two-bit counter. The counter counts modulo 3 how many words so far had a one in that bit. The two registers are updated in a fixed order for each word. `lower_q` is computed first. `higher_q` is then computed from the freshly updated `lower_q` value of the same word. Both steps complete within one clock cycle.

A start pulse clears the state and arms the block. The beat marked as last closes the stream. On the next clock, the value of `lower_q` after that beat appears on the result output and a one-cycle done pulse is raised. For an arbitrary stream, each result bit is one exactly when that bit was set in a number of words that leaves remainder 1 when divided by 3.

Top module: `triple_cancel_top`

## Requirements
- R1: While reset is asserted and after its release, `done_o` is 0 and `result_o` is 0.
- R2: A `start_i` pulse clears both per-bit counters. The result of the next stream does not depend on any words accepted before that pulse.
- R3: After reset, beats are ignored until a `start_i` pulse has been seen. Before that pulse, no `done_o` is raised and `result_o` keeps its value.
- R4: For an accepted stream, bit b of the result is 1 exactly when the count of accepted words with bit b set, taken modulo 3, equals 1. For streams where every value occurs three times except one value, the result is that single value, and this holds for negative values too. No bit's counter ever holds the unused state in which both registers are 1.
- R5: When the beat with `in_last_i`=1 is accepted, `done_o` is 1 in the following cycle only, and `result_o` carries the answer in that same cycle.
- R6: After the last beat, the block ignores further beats until the next `start_i` pulse. No `done_o` is raised and `result_o` does not change.
- R7: Cycles with `in_valid_i`=0 do not affect the result, whatever `in_data_i` and `in_last_i` carry.
- R8: `result_o` changes only in a cycle in which `done_o` is 1. Otherwise it holds its last value.
- R9: `start_i` takes priority over a beat in the same cycle. That beat is discarded, and a stream that has not yet completed gives no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the counters and arms the block for a new stream |
| in_valid_i | input | 1 | A word is present on `in_data_i` in this cycle |
| in_last_i | input | 1 | The word in this cycle is the final one of the stream |
| in_data_i | input | 32 | Stream word |
| result_o | output | 32 | Registered answer, updated together with `done_o` |
| done_o | output | 1 | One-cycle pulse: a new answer is present on `result_o` |

## Verification
A wrong state update in any bit shows up at the ports only when the stream ends. `done_o` then rises one cycle after the last beat with a wrong bit in `result_o`, so every stream is checked against the bench's own count-modulo-3 reference for each bit. Errors in the arming logic show up sooner: a `done_o` that is raised or missing, or a result that moves, in the cycle after a beat that should have been ignored. An illegal counter state (both registers set in one bit) is flagged by an assertion in the cycle it appears, without waiting for the stream to end.

// File: rtl/triple_pkg.sv
package triple_pkg;
  // Per-bit modulo-3 counter: {hi,lo} = 00 -> 0, 01 -> 1, 10 -> 2.
  typedef struct packed {
    logic hi;
    logic lo;
  } m3_t;
endpackage

// File: rtl/triple_cell.sv
module triple_cell
  import triple_pkg::*;
(
  input  m3_t  cur_i,
  input  logic x_i,
  output m3_t  nxt_o
);
  logic lo_new;

  // Ordered update: hi uses the lo value already updated for this word.
  always_comb begin
    lo_new    = (cur_i.lo ^ x_i) & ~cur_i.hi;
    nxt_o.lo  = lo_new;
    nxt_o.hi  = (cur_i.hi ^ x_i) & ~lo_new;
  end
endmodule

// File: rtl/triple_ctrl.sv
module triple_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  input  logic last_i,
  output logic accept_o,
  output logic finish_o,
  output logic armed_o,
  output logic done_o
);
  logic armed_q, done_q;

  assign accept_o = armed_q & valid_i & ~start_i;
  assign finish_o = accept_o & last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      if (finish_o) armed_q <= 1'b0;
      done_q <= finish_o;
    end
  end

  assign armed_o = armed_q;
  assign done_o  = done_q;
endmodule

// File: rtl/triple_result.sv
module triple_result #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/triple_cancel_top.sv
module triple_cancel_top
  import triple_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  logic              accept, finish, armed_q;
  logic [DATA_W-1:0] lower_q, higher_q, lower_d, higher_d;

  triple_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .valid_i  (in_valid_i),
    .last_i   (in_last_i),
    .accept_o (accept),
    .finish_o (finish),
    .armed_o  (armed_q),
    .done_o   (done_o)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    m3_t cur, nxt;
    assign cur.lo = lower_q[b];
    assign cur.hi = higher_q[b];
    triple_cell u_cell (
      .cur_i (cur),
      .x_i   (in_data_i[b]),
      .nxt_o (nxt)
    );
    assign lower_d[b]  = nxt.lo;
    assign higher_d[b] = nxt.hi;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lower_q  <= '0;
      higher_q <= '0;
    end else if (start_i) begin
      lower_q  <= '0;
      higher_q <= '0;
    end else if (accept) begin
      lower_q  <= lower_d;
      higher_q <= higher_d;
    end
  end

  triple_result #(.DATA_W(DATA_W)) u_result (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (finish),
    .d_i    (lower_d),
    .q_o    (result_o)
  );
endmodule

// File: rtl/triple_cancel_chk.sv
module triple_cancel_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              in_valid_i,
  input logic              in_last_i,
  input logic              armed_i,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic [DATA_W-1:0] lower_i,
  input logic [DATA_W-1:0] higher_i
);
  a_r1_reset_quiet: assert property (@(posedge clk_i) !rst_ni |-> (!done_o && result_o == '0));

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (lower_i == '0 && higher_i == '0));

  a_r4_no_illegal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lower_i & higher_i) == '0);

  a_r5_done_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && in_valid_i && in_last_i && !start_i) |=> done_o);

  a_r5_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_idle_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !done_o);

  a_r8_result_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r9_start_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

bind triple_cancel_top triple_cancel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .in_last_i  (in_last_i),
  .armed_i    (armed_q),
  .done_o     (done_o),
  .result_o   (result_o),
  .lower_i    (lower_q),
  .higher_i   (higher_q)
);

// File: tb/triple_cancel_top_bench.sv
`timescale 1ns/1ps
module triple_cancel_top_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0, in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [W-1:0] in_data_i = '0;
  logic [W-1:0] result_o;
  logic         done_o;

  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [W-1:0] sbuf [0:63];

  always #2 clk = ~clk;

  triple_cancel_top #(.DATA_W(W)) u_triple_cancel_top (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_last_i(in_last_i), .in_data_i(in_data_i), .result_o(result_o), .done_o(done_o)
  );

  function automatic logic [31:0] nxt_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Reference: bit set iff its occurrence count mod 3 equals 1
  function automatic logic [W-1:0] ref_val(int n);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) begin
      int cnt = 0;
      for (int i = 0; i < n; i++) cnt += int'(sbuf[i][b]);
      r[b] = (cnt % 3 == 1);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(bit with_beat);
    @(negedge clk);
    start_i = 1'b1; in_valid_i = with_beat; in_data_i = '1; in_last_i = with_beat;
    @(negedge clk);
    start_i = 1'b0; in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic run_stream(int n, bit gaps, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_data_i = sbuf[i]; in_last_i = (i == n - 1);
      if (gaps && i < n - 1) begin
        @(negedge clk);
        in_valid_i = 1'b0; in_data_i = nxt_rand(); in_last_i = 1'b1; // R7 noise
      end
    end
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    chk({tag, " R5 done"}, W'(done_o), W'(1));
    chk({tag, " R4 result"}, result_o, ref_val(n));
    @(negedge clk);
    chk({tag, " R5 done single cycle"}, W'(done_o), W'(0));
  endtask

  task automatic stray_beat(string tag, logic [W-1:0] hold);
    @(negedge clk);
    in_valid_i = 1'b1; in_data_i = nxt_rand(); in_last_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    chk({tag, " no done"}, W'(done_o), W'(0));
    @(negedge clk);
    chk({tag, " no done late"}, W'(done_o), W'(0));
    chk({tag, " result held"}, result_o, hold);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] arr10 [0:9];
    repeat (3) @(negedge clk);
    chk("R1 done in reset", W'(done_o), W'(0));
    chk("R1 result in reset", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", W'(done_o), W'(0));
    chk("R1 result after reset", result_o, '0);

    stray_beat("R3 unarmed", '0);

    // R4 ten-element stream with a single 4
    arr10 = '{32'd5, 32'd1, 32'd1, 32'd1, 32'd9, 32'd5, 32'd5, 32'd9, 32'd4, 32'd9};
    for (int i = 0; i < 10; i++) sbuf[i] = arr10[i];
    pulse_start(1'b0);
    run_stream(10, 1'b0, "R4 ten");
    chk("R4 ten is 4", result_o, 32'd4);

    stray_beat("R6 after last", 32'd4);
    stray_beat("R8 hold again", 32'd4);

    // R4 negative values
    sbuf[0] = -32'sd7; sbuf[1] = 32'h8000_0000; sbuf[2] = -32'sd7;
    sbuf[3] = -32'sd123; sbuf[4] = 32'h8000_0000; sbuf[5] = -32'sd7;
    sbuf[6] = 32'h8000_0000;
    pulse_start(1'b0);
    run_stream(7, 1'b1, "R4 negative R7 gaps");
    chk("R4 negative single", result_o, -32'sd123);

    // R2 start mid-stream discards prior beats
    sbuf[0] = 32'hDEAD_BEEF; sbuf[1] = 32'h0F0F_0F0F;
    pulse_start(1'b0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid_i = 1'b1; in_data_i = sbuf[i]; in_last_i = 1'b0;
    end
    // R9 start with a last beat in the same cycle: beat dropped, no done
    pulse_start(1'b1);
    chk("R9 no done on start beat", W'(done_o), W'(0));
    sbuf[0] = 32'h0000_00A5;
    run_stream(1, 1'b0, "R2 restart");
    chk("R2 R9 clean result", result_o, 32'h0000_00A5);

    // Sweep: tripled sets with one single, plus arbitrary streams
    for (int t = 0; t < 40; t++) begin
      int n;
      if (t < 20) begin
        int k = int'(nxt_rand() % 5);
        logic [W-1:0] v;
        n = 0;
        for (int j = 0; j < k; j++) begin
          v = nxt_rand();
          sbuf[n] = v; sbuf[n+1] = v; sbuf[n+2] = v; n += 3;
        end
        sbuf[n] = nxt_rand(); n++;
        // rotate so the single is not always last
        for (int r = 0; r < t % 4; r++) begin
          logic [W-1:0] tmp = sbuf[n-1];
          for (int j = n - 1; j > 0; j--) sbuf[j] = sbuf[j-1];
          sbuf[0] = tmp;
        end
      end else begin
        n = 1 + int'(nxt_rand() % 20);
        for (int j = 0; j < n; j++) sbuf[j] = nxt_rand();
      end
      pulse_start(1'b0);
      run_stream(n, t[0], "R4 sweep");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule